// File: doc/BRIEF.md
# Dual-Channel Timer Waveform Generator

This block is an 8-bit timer counter with two compare channels, named A and B. Each channel drives one output pin. A 3-bit mode word selects how the counter runs. It can count up freely, count up and clear when it reaches a compare value, count up as a fast PWM, or count up and down as a phase-correct PWM. In the modes that use a compare value as the cycle end, channel A's compare value sets TOP. Each channel has its own 2-bit output-action field. The meaning of that field depends on the mode class: non-PWM, fast PWM or phase-correct. The chosen action sets, clears or toggles a per-channel waveform level on compare matches, at TOP or at BOTTOM.

When a channel's action field asks for the pin, the waveform level replaces the pin's ordinary port value. This happens only if the pin's direction bit marks it as an output. The block also exposes the counter value, a per-channel override indication, one-cycle match pulses and an overflow pulse.

In the PWM modes, new compare values are held in a shadow stage until the counter reaches the point in the period where they are allowed to take effect. This prevents glitches. In the non-PWM modes, a new compare value takes effect at once.

Top module: `tc_wavegen`

## Requirements
- R1: With a channel's action field at 00, its override output is 0 and its pin equals its port input, in every mode.
- R2: When the override output is 1, the pin shows the waveform level only while the direction bit is 1; with the direction bit at 0 the pin equals the port input.
- R3: In non-PWM mode classes (mode words 000, 010, and the reserved 100 and 110), a compare match changes the waveform level on the next clock edge. Action field 01 toggles the level, 10 clears it and 11 sets it.
- R4: In fast PWM (mode words 011 and 111), action field 10 sets the level when the counter wraps from TOP to 0 and clears it on a match; 11 does the opposite. When the compare value equals TOP, the wrap action wins.
- R5: Action field 01 disconnects channel B in both PWM classes. It also disconnects channel A in both PWM classes when mode bit 2 is 0. A disconnected channel has override 0, its pin follows the port input, and its waveform level does not change.
- R6: In phase-correct PWM (mode words 001 and 101), action field 10 clears the level on a match when the counter leaves that value upward, and sets it on a match when the counter leaves downward. Action field 11 does the reverse.
- R7: With mode bit 2 at 1, channel A with action field 01 is driven in both PWM classes and toggles on each match.
- R8: In phase-correct PWM, when channel A's effective compare value equals TOP and the upper bit of its action field is 1, the ordinary match is not used. The down-count action (set for 10, clear for 11) is applied when the counter is at TOP.
- R9: TOP is channel A's effective compare value for mode words 010, 101 and 111, and 255 for all other mode words.
- R10: Non-PWM and fast PWM modes count up and go to 0 after TOP. Phase-correct mode counts up to TOP, then down to 0, reversing at each end.
- R11: In PWM classes, the effective compare values are loaded from the inputs on the clock edge at which the counter leaves TOP. In non-PWM classes, the inputs are used directly in the same cycle.
- R12: The match flag for a channel is high during any enabled cycle in which the count equals that channel's effective compare value. The overflow flag is high during enabled cycles at TOP in the up-counting classes, and at 0 in phase-correct. While the enable is 0, the count, the waveform levels and the shadow values in PWM classes hold, and all flags are 0.
- R13: A synchronous reset clears the count, both waveform levels and both shadow compare values, and makes the next phase-correct step upward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cnt_en | input | 1 | Count enable; when 0 the block holds |
| wgm | input | 3 | Counting mode word |
| com_a | input | 2 | Output-action field, channel A |
| com_b | input | 2 | Output-action field, channel B |
| cmp_a | input | W | Compare value input, channel A |
| cmp_b | input | W | Compare value input, channel B |
| dir_a | input | 1 | Pin A direction, 1 = output |
| dir_b | input | 1 | Pin B direction, 1 = output |
| port_a | input | 1 | Ordinary port value for pin A |
| port_b | input | 1 | Ordinary port value for pin B |
| count | output | W | Current counter value |
| pin_a | output | 1 | Resolved pin A level |
| pin_b | output | 1 | Resolved pin B level |
| ovr_a | output | 1 | Channel A takes over its pin |
| ovr_b | output | 1 | Channel B takes over its pin |
| match_a | output | 1 | Channel A compare match pulse |
| match_b | output | 1 | Channel B compare match pulse |
| ovf | output | 1 | Overflow pulse |

## Verification
The count, the shadow compare values and the waveform levels change on a clock edge. The match and overflow flags, the override outputs and the pins are combinational from that registered state and the current inputs. They are therefore due in the same cycle as the count value that causes them. A match moves a pin one cycle later, when the count already shows the following value. A compare value written in a PWM class becomes visible only after the edge that leaves TOP.

The bench drives its inputs and compares the outputs at the falling clock edge. Its reference model advances on the rising edge, so every comparison sees the state after exactly one update. The directed checks wait on the count output and sample at the cycle worked out from these rules.

// File: rtl/tcw_pkg.sv
package tcw_pkg;

  typedef enum logic [1:0] {
    K_NORM = 2'd0,
    K_CTC  = 2'd1,
    K_FAST = 2'd2,
    K_PC   = 2'd3
  } kind_e;

  // Mode word to counting class; unlisted words count like free-running.
  function automatic kind_e wgm_kind(input logic [2:0] w);
    case (w)
      3'b001, 3'b101: return K_PC;
      3'b010:         return K_CTC;
      3'b011, 3'b111: return K_FAST;
      default:        return K_NORM;
    endcase
  endfunction

  // True when channel A's compare value sets the end of the count cycle.
  function automatic logic top_from_a(input logic [2:0] w);
    return (w == 3'b010) || (w == 3'b101) || (w == 3'b111);
  endfunction

  function automatic logic is_pwm(input kind_e k);
    return (k == K_FAST) || (k == K_PC);
  endfunction

  // Whether the channel takes the pin over from the port.
  function automatic logic pin_driven(input kind_e k, input logic [1:0] act,
                                      input logic tgl_ok);
    if (act == 2'b00) return 1'b0;
    if (is_pwm(k) && act == 2'b01 && !tgl_ok) return 1'b0;
    return 1'b1;
  endfunction

  // Next waveform level for one enabled clock.
  function automatic logic wave_next(input kind_e k, input logic [1:0] act,
                                     input logic tgl_ok, input logic hit,
                                     input logic at_top, input logic up,
                                     input logic cur);
    logic n;
    n = cur;
    case (k)
      K_FAST: begin
        case (act)
          2'b01: if (tgl_ok && hit) n = !cur;
          2'b10: if (at_top) n = 1'b1; else if (hit) n = 1'b0;
          2'b11: if (at_top) n = 1'b0; else if (hit) n = 1'b1;
          default: n = cur;
        endcase
      end
      K_PC: begin
        case (act)
          2'b01: if (tgl_ok && hit) n = !cur;
          2'b10: if (hit) n = !up;
          2'b11: if (hit) n = up;
          default: n = cur;
        endcase
      end
      default: begin
        if (hit) begin
          case (act)
            2'b01:   n = !cur;
            2'b10:   n = 1'b0;
            2'b11:   n = 1'b1;
            default: n = cur;
          endcase
        end
      end
    endcase
    return n;
  endfunction

endpackage

// File: rtl/tcw_counter.sv
module tcw_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         is_pc,
  input  logic [W-1:0] top,
  output logic [W-1:0] cnt,
  output logic         lv_up,
  output logic         at_top,
  output logic         at_bot
);

  logic         dir_q;
  logic [W-1:0] cnt_nxt;

  assign at_top = (cnt == top);
  assign at_bot = (cnt == '0);

  // Direction in which the counter leaves its present value.
  always_comb begin
    if (!is_pc)          lv_up = 1'b1;
    else if (at_bot)     lv_up = 1'b1;
    else if (cnt >= top) lv_up = 1'b0;
    else                 lv_up = dir_q;
  end

  always_comb begin
    if (is_pc)       cnt_nxt = lv_up ? cnt + 1'b1 : cnt - 1'b1;
    else if (at_top) cnt_nxt = '0;
    else             cnt_nxt = cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      dir_q <= 1'b1;
    end else if (en) begin
      cnt   <= cnt_nxt;
      dir_q <= lv_up;
    end
  end

  assert_pc_step_R10: assert property (@(posedge clk) disable iff (rst)
    (en && is_pc) |=> (cnt == W'($past(cnt) + 1'b1)) || (cnt == W'($past(cnt) - 1'b1)));

  assert_wrap_R10: assert property (@(posedge clk) disable iff (rst)
    (en && !is_pc && at_top) |=> (cnt == '0));

  assert_hold_R12: assert property (@(posedge clk) disable iff (rst)
    (!en) |=> $stable(cnt));

endmodule

// File: rtl/tcw_cmp_buf.sv
module tcw_cmp_buf #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= din;
  end

  assert_buf_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (!load) |=> $stable(q));

  assert_buf_load_R11: assert property (@(posedge clk) disable iff (rst)
    load |=> (q == $past(din)));

endmodule

// File: rtl/tcw_channel.sv
module tcw_channel
  import tcw_pkg::*;
#(
  parameter bit IS_A = 1'b1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  kind_e      kind,
  input  logic       wgm2,
  input  logic [1:0] act,
  input  logic       hit,
  input  logic       at_top,
  input  logic       lv_up,
  input  logic       a_eq_top,
  output logic       wave,
  output logic       drv
);

  logic tgl_ok;
  logic top_cmp_special;
  logic eff_hit;
  logic eff_up;

  assign tgl_ok = IS_A && wgm2;
  assign drv    = pin_driven(kind, act, tgl_ok);

  // Channel A in phase-correct with compare at TOP: act at TOP as if counting down.
  assign top_cmp_special = IS_A && (kind == K_PC) && act[1] && a_eq_top;
  assign eff_hit = top_cmp_special ? at_top : hit;
  assign eff_up  = top_cmp_special ? 1'b0 : lv_up;

  always_ff @(posedge clk) begin
    if (rst)     wave <= 1'b0;
    else if (en) wave <= wave_next(kind, act, tgl_ok, eff_hit, at_top, eff_up, wave);
  end

  assert_nonpwm_clear_R3: assert property (@(posedge clk) disable iff (rst)
    (en && (kind == K_NORM || kind == K_CTC) && act == 2'b10 && hit) |=> !wave);

  assert_fast_bottom_R4: assert property (@(posedge clk) disable iff (rst)
    (en && kind == K_FAST && act == 2'b10 && at_top) |=> wave);

  assert_idle_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!drv) |=> $stable(wave));

  assert_pc_top_R8: assert property (@(posedge clk) disable iff (rst)
    (en && top_cmp_special && at_top && act == 2'b11) |=> !wave);

endmodule

// File: rtl/tc_wavegen.sv
module tc_wavegen
  import tcw_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cnt_en,
  input  logic [2:0]   wgm,
  input  logic [1:0]   com_a,
  input  logic [1:0]   com_b,
  input  logic [W-1:0] cmp_a,
  input  logic [W-1:0] cmp_b,
  input  logic         dir_a,
  input  logic         dir_b,
  input  logic         port_a,
  input  logic         port_b,
  output logic [W-1:0] count,
  output logic         pin_a,
  output logic         pin_b,
  output logic         ovr_a,
  output logic         ovr_b,
  output logic         match_a,
  output logic         match_b,
  output logic         ovf
);

  localparam int NCH = 2;

  kind_e        kind;
  logic         pwm;
  logic         a_is_top;
  logic         load;
  logic [W-1:0] top;
  logic [W-1:0] cnt;
  logic         lv_up;
  logic         at_top;
  logic         at_bot;
  logic         a_eq_top;

  logic [W-1:0]   cmp_in [NCH];
  logic [W-1:0]   held   [NCH];
  logic [W-1:0]   eff    [NCH];
  logic [1:0]     act_in [NCH];
  logic [NCH-1:0] hit;
  logic [NCH-1:0] dir_in;
  logic [NCH-1:0] port_in;
  logic [NCH-1:0] wave;
  logic [NCH-1:0] drv;
  logic [NCH-1:0] pin;

  assign kind     = wgm_kind(wgm);
  assign pwm      = is_pwm(kind);
  assign a_is_top = top_from_a(wgm);

  assign cmp_in[0] = cmp_a;
  assign cmp_in[1] = cmp_b;
  assign act_in[0] = com_a;
  assign act_in[1] = com_b;
  assign dir_in    = {dir_b, dir_a};
  assign port_in   = {port_b, port_a};

  // Shadow stage: transparent outside PWM, loads on the edge leaving TOP inside.
  assign load = !pwm || (cnt_en && at_top);

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      tcw_cmp_buf #(.W(W)) u_buf (
        .clk  (clk),
        .rst  (rst),
        .load (load),
        .din  (cmp_in[c]),
        .q    (held[c])
      );

      assign eff[c] = pwm ? held[c] : cmp_in[c];
      assign hit[c] = cnt_en && (cnt == eff[c]);

      tcw_channel #(.IS_A(c == 0)) u_chan (
        .clk      (clk),
        .rst      (rst),
        .en       (cnt_en),
        .kind     (kind),
        .wgm2     (wgm[2]),
        .act      (act_in[c]),
        .hit      (hit[c]),
        .at_top   (at_top),
        .lv_up    (lv_up),
        .a_eq_top (a_eq_top),
        .wave     (wave[c]),
        .drv      (drv[c])
      );

      assign pin[c] = (drv[c] && dir_in[c]) ? wave[c] : port_in[c];
    end
  endgenerate

  assign top      = a_is_top ? eff[0] : {W{1'b1}};
  assign a_eq_top = (eff[0] == top);

  tcw_counter #(.W(W)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .en     (cnt_en),
    .is_pc  (kind == K_PC),
    .top    (top),
    .cnt    (cnt),
    .lv_up  (lv_up),
    .at_top (at_top),
    .at_bot (at_bot)
  );

  assign count   = cnt;
  assign pin_a   = pin[0];
  assign pin_b   = pin[1];
  assign ovr_a   = drv[0];
  assign ovr_b   = drv[1];
  assign match_a = hit[0];
  assign match_b = hit[1];
  assign ovf     = cnt_en && ((kind == K_PC) ? at_bot : at_top);

endmodule

// File: tb/test_tc_wavegen.sv
module test_tc_wavegen;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cnt_en = 1'b0;
  logic [2:0]   wgm = '0;
  logic [1:0]   com_a = '0, com_b = '0;
  logic [W-1:0] cmp_a = '0, cmp_b = '0;
  logic         dir_a = 1'b0, dir_b = 1'b0, port_a = 1'b0, port_b = 1'b0;
  logic [W-1:0] count;
  logic         pin_a, pin_b, ovr_a, ovr_b, match_a, match_b, ovf;

  always #5 clk = ~clk;

  tc_wavegen #(.W(W)) i_tc_wavegen (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .wgm(wgm), .com_a(com_a), .com_b(com_b),
    .cmp_a(cmp_a), .cmp_b(cmp_b), .dir_a(dir_a), .dir_b(dir_b),
    .port_a(port_a), .port_b(port_b), .count(count), .pin_a(pin_a), .pin_b(pin_b),
    .ovr_a(ovr_a), .ovr_b(ovr_b), .match_a(match_a), .match_b(match_b), .ovf(ovf)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  int m_cnt, m_buf_a, m_buf_b;
  bit m_up, m_wa, m_wb;

  // class code: 0 free-run, 1 clear-on-compare, 2 fast, 3 phase-correct (R9)
  function automatic int f_cls();
    if (wgm == 3'd1 || wgm == 3'd5) return 3;
    if (wgm == 3'd3 || wgm == 3'd7) return 2;
    if (wgm == 3'd2) return 1;
    return 0;
  endfunction

  function automatic int f_eff(bit chb);
    if (f_cls() >= 2) return chb ? m_buf_b : m_buf_a;
    return chb ? int'(cmp_b) : int'(cmp_a);
  endfunction

  function automatic int f_top();
    if (wgm == 3'd2 || wgm == 3'd5 || wgm == 3'd7) return f_eff(1'b0);
    return 255;
  endfunction

  function automatic bit f_leave_up();
    if (f_cls() != 3) return 1'b1;
    if (m_cnt == 0) return 1'b1;
    if (m_cnt >= f_top()) return 1'b0;
    return m_up;
  endfunction

  function automatic bit f_owns(bit chb);
    int fld;
    fld = chb ? int'(com_b) : int'(com_a);
    if (fld == 0) return 1'b0;
    if (f_cls() >= 2 && fld == 1 && (chb || !wgm[2])) return 1'b0;
    return 1'b1;
  endfunction

  function automatic bit f_level(bit chb, bit cur);
    int  fld;
    bit  m, t, u, tg;
    fld = chb ? int'(com_b) : int'(com_a);
    m   = (m_cnt == f_eff(chb));
    t   = (m_cnt == f_top());
    u   = f_leave_up();
    tg  = !chb && wgm[2];
    if (!chb && f_cls() == 3 && fld >= 2 && f_eff(1'b0) == f_top()) begin
      m = t;
      u = 1'b0;
    end
    if (f_cls() == 2) begin
      if (fld == 1) return (m && tg) ? !cur : cur;
      if (fld == 2) return t ? 1'b1 : (m ? 1'b0 : cur);
      if (fld == 3) return t ? 1'b0 : (m ? 1'b1 : cur);
      return cur;
    end
    if (f_cls() == 3) begin
      if (fld == 1) return (m && tg) ? !cur : cur;
      if (fld == 2) return m ? !u : cur;
      if (fld == 3) return m ? u : cur;
      return cur;
    end
    if (!m) return cur;
    if (fld == 1) return !cur;
    if (fld == 2) return 1'b0;
    if (fld == 3) return 1'b1;
    return cur;
  endfunction

  always @(posedge clk) begin : mdl
    bit nwa, nwb, u;
    int nc, t;
    if (rst) begin
      m_cnt = 0; m_up = 1'b1; m_buf_a = 0; m_buf_b = 0; m_wa = 1'b0; m_wb = 1'b0;
    end else begin
      t   = f_top();
      u   = f_leave_up();
      nwa = f_level(1'b0, m_wa);
      nwb = f_level(1'b1, m_wb);
      if (f_cls() == 3) nc = u ? m_cnt + 1 : m_cnt - 1;
      else              nc = (m_cnt == t) ? 0 : (m_cnt + 1) % 256;
      if (f_cls() < 2 || (cnt_en && m_cnt == t)) begin
        m_buf_a = int'(cmp_a);
        m_buf_b = int'(cmp_b);
      end
      if (cnt_en) begin
        m_wa = nwa; m_wb = nwb; m_cnt = nc; m_up = u;
      end
    end
  end

  task automatic compare_all(input string req);
    bit ea, eb;
    ea = f_owns(1'b0);
    eb = f_owns(1'b1);
    chk(req, "count", int'(count), m_cnt);
    chk(req, "ovr_a", int'(ovr_a), int'(ea));
    chk(req, "ovr_b", int'(ovr_b), int'(eb));
    chk(req, "pin_a", int'(pin_a), int'((ea && dir_a) ? m_wa : port_a));
    chk(req, "pin_b", int'(pin_b), int'((eb && dir_b) ? m_wb : port_b));
    chk(req, "match_a", int'(match_a), int'(cnt_en && m_cnt == f_eff(1'b0)));
    chk(req, "match_b", int'(match_b), int'(cnt_en && m_cnt == f_eff(1'b1)));
    chk(req, "ovf", int'(ovf),
        int'(cnt_en && ((f_cls() == 3) ? (m_cnt == 0) : (m_cnt == f_top()))));
  endtask

  // ---------------- stimulus table ----------------
  typedef struct packed {
    logic [2:0]  wgm;
    logic [1:0]  ca;
    logic [1:0]  cb;
    logic [7:0]  oa;
    logic [7:0]  ob;
    logic [10:0] cyc;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{3'd0, 2'd1, 2'd3, 8'd40,  8'd200, 11'd600},  // R3 R10 free-run toggle/set
    '{3'd2, 2'd1, 2'd2, 8'd30,  8'd10,  11'd200},  // R3 R9 clear-on-compare
    '{3'd3, 2'd2, 2'd3, 8'd100, 8'd255, 11'd700},  // R4 R11 fast, B at TOP
    '{3'd7, 2'd1, 2'd1, 8'd20,  8'd5,   11'd200},  // R7 R5 fast A toggles, B reserved
    '{3'd1, 2'd2, 2'd3, 8'd255, 8'd60,  11'd1100}, // R6 R8 phase-correct, A at TOP
    '{3'd5, 2'd3, 2'd2, 8'd25,  8'd7,   11'd300},  // R6 R8 R9 phase-correct TOP from A
    '{3'd3, 2'd1, 2'd2, 8'd50,  8'd0,   11'd600},  // R5 A disconnected, B at BOTTOM
    '{3'd6, 2'd3, 2'd1, 8'd9,   8'd250, 11'd600},  // R9 reserved word acts free-run
    '{3'd5, 2'd1, 2'd2, 8'd16,  8'd20,  11'd200},  // R7 phase-correct toggle
    '{3'd7, 2'd2, 2'd2, 8'd30,  8'd40,  11'd200}   // R4 fast compare equals TOP
  };

  task automatic wait_cnt(input int v);
    for (int g = 0; g < 700; g++) begin
      @(negedge clk);
      if (int'(count) == v) return;
    end
    chk("R10", "wait for count", int'(count), v);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin : main
    // R13 R1: reset state with the action fields at 00
    dir_a = 1'b1; dir_b = 1'b1; port_a = 1'b1; port_b = 1'b0;
    repeat (2) @(negedge clk);
    chk("R13", "count after reset", int'(count), 0);
    chk("R1", "ovr_a idle", int'(ovr_a), 0);
    chk("R1", "pin_a follows port", int'(pin_a), 1);
    chk("R1", "pin_b follows port", int'(pin_b), 0);
    port_a = 1'b0; port_b = 1'b1;
    #1;
    chk("R1", "pin_a follows port", int'(pin_a), 0);
    chk("R1", "pin_b follows port", int'(pin_b), 1);

    // table walk against the model
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      rst = 1'b1; cnt_en = 1'b1;
      wgm = VEC[v].wgm; com_a = VEC[v].ca; com_b = VEC[v].cb;
      cmp_a = VEC[v].oa; cmp_b = VEC[v].ob;
      dir_a = 1'b1; dir_b = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      for (int k = 0; k < int'(VEC[v].cyc); k++) begin
        @(negedge clk);
        compare_all("R12");
        cnt_en = (k % 11) != 10;
        port_a = k[2];
        port_b = k[3];
        dir_b  = (k % 97) < 90;
        if (k == int'(VEC[v].cyc) / 2) cmp_b = cmp_b + 8'd3;
      end
    end

    // R11: fast PWM holds a new compare value until the wrap
    cnt_en = 1'b1; wgm = 3'd3; com_a = 2'd0; com_b = 2'd0;
    cmp_a = 8'd200; cmp_b = 8'd12; dir_a = 1'b1; dir_b = 1'b1;
    do_reset();
    wait_cnt(12);
    chk("R11", "match_b before wrap", int'(match_b), 0);
    wait_cnt(0);
    wait_cnt(12);
    chk("R11", "match_b after wrap", int'(match_b), 1);

    // R11 R9: clear-on-compare uses inputs at once, TOP from channel A
    wgm = 3'd2; cmp_a = 8'd20; cmp_b = 8'd12;
    do_reset();
    wait_cnt(12);
    chk("R11", "match_b immediate", int'(match_b), 1);
    // R12: enable low holds count and silences flags
    cnt_en = 1'b0;
    @(negedge clk);
    chk("R12", "count held", int'(count), 12);
    chk("R12", "match_b while held", int'(match_b), 0);
    chk("R12", "ovf while held", int'(ovf), 0);
    cnt_en = 1'b1;
    wait_cnt(20);
    chk("R9", "ovf at compare-A TOP", int'(ovf), 1);
    @(negedge clk);
    chk("R9", "count after TOP", int'(count), 0);

    // R2: direction bit gates the override
    wgm = 3'd0; com_a = 2'd3; cmp_a = 8'd3; dir_a = 1'b0; port_a = 1'b0;
    do_reset();
    wait_cnt(8);
    chk("R2", "ovr_a asserted", int'(ovr_a), 1);
    chk("R2", "pin_a input-direction", int'(pin_a), 0);
    dir_a = 1'b1;
    #1;
    chk("R2", "pin_a output-direction", int'(pin_a), 1);

    // R13: reset in mid-run clears the level and the count
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R13", "count after mid reset", int'(count), 0);
    chk("R13", "pin_a after mid reset", int'(pin_a), 0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule